// File: doc/BRIEF.md
# Set-Associative Hit/Miss Tracker

This block keeps only the tag state of a set-associative cache. It stores no data, and it tells the surrounding timing logic whether an access would hit or miss. Each request carries a 32-bit address and a direction bit. The hit answer is combinational, so it is valid in the same cycle as the qualified request. Any state change from that request takes effect at the next clock edge.

The cache shape comes from three log2 parameters: total size, associativity and line size. The defaults describe a 4096-byte, 4-way cache with 32-byte lines. A larger instance, such as 8192 bytes with the same ways and line size, only needs a different size parameter.

The tag is the address with every bit below bit (size_log2 − assoc_log2) cleared. The set index is the field between the line offset and that tag boundary. Every set holds one tag per way and a round-robin pointer. Only a read miss allocates a way. A single register remembers the index field of the line touched most recently. A repeat access to that line is reported as a hit without a tag lookup.

Top module: `cache_hit_tracker`

## Requirements
- R1: While `reqValid` is high, `accessHit` is high in the same cycle when any way of the set selected by address bits [TAG_SHIFT-1:LINE_LOG2] holds a tag equal to address bits [31:TAG_SHIFT]. TAG_SHIFT is SIZE_LOG2 − ASSOC_LOG2, which is 10 with the defaults. The bits below LINE_LOG2 have no effect on the result.
- R2: A read miss (`reqWrite` = 0) writes the tag into the way named by that set's pointer. The pointer then advances by one, wrapping modulo the number of ways. The next access to the same line hits.
- R3: Round-robin replacement applies per set. After five distinct tags are read into one 4-way set, the first tag misses and the third still hits.
- R4: A write miss (`reqWrite` = 1) changes no tag, pointer or last-line state. A repeat of the same write misses again, and a later read of that line also misses. A write to a line already held hits.
- R5: When an access has the same index field as the last-line register, it is reported as a hit and nothing is allocated, even if the tag differs. The register takes the index field of every tag hit and every read allocation.
- R6: While `reqValid` is low, `accessHit` is 0 and no state changes, whatever the address and direction inputs carry.
- R7: Synchronous reset (`rst` high) sets every tag to 0, every pointer to way 0, and the last-line register to all ones. After reset an address with tag 0 hits, and the first read miss in a set fills way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Qualifies the access on this cycle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 32 | Byte address of the access |
| accessHit | output | 1 | Same-cycle hit indication for a valid access |

## Verification
Some properties are checked every cycle. The hit output stays low when no request is valid. A read miss that is repeated right away must hit. A write miss that is repeated right away must miss again. A hit makes the next access to the same index field a hit. The control never allocates on a write or on a hit. Round-robin eviction depth, the shortcut hit on a different tag, state kept across idle stretches and the tag-0 hits after reset all depend on longer histories. The bench shows these through directed sequences and a reference-model scoreboard over random traffic.

// File: rtl/cache_track_pkg.sv
package cache_track_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic allocate;   // write tag into the pointed way, advance pointer
    logic touchLast;  // load the last-line register
  } trackStrobe_t;

endpackage

// File: rtl/cache_track_dpath.sv
module cache_track_dpath
  import cache_track_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_LOG2  = 12,
  parameter int ASSOC_LOG2 = 2,
  parameter int LINE_LOG2  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  trackStrobe_t      strobe,
  output logic              shortcutMatch,
  output logic              wayMatch
);

  localparam int TAG_SHIFT = SIZE_LOG2 - ASSOC_LOG2;
  localparam int SET_W     = TAG_SHIFT - LINE_LOG2;
  localparam int SETS      = 1 << SET_W;
  localparam int WAYS      = 1 << ASSOC_LOG2;
  localparam int TAG_W     = ADDR_W - TAG_SHIFT;
  localparam int PTR_W     = (ASSOC_LOG2 > 0) ? ASSOC_LOG2 : 1;
  localparam logic [ADDR_W-1:0] LINE_MASK =
    ~({ADDR_W{1'b1}} << TAG_SHIFT) & ({ADDR_W{1'b1}} << LINE_LOG2);

  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [PTR_W-1:0]  nextWay [SETS];
  logic [ADDR_W-1:0] lastLine;

  logic [ADDR_W-1:0] lineMasked;
  logic [SET_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WAYS-1:0]   wayHitVec;
  logic [PTR_W-1:0]  curPtr;

  assign lineMasked = reqAddr & LINE_MASK;
  assign lineIdx    = lineMasked[TAG_SHIFT-1:LINE_LOG2];
  assign reqTag     = reqAddr[ADDR_W-1:TAG_SHIFT];
  assign curPtr     = nextWay[lineIdx];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign wayHitVec[w] = (tagMem[lineIdx][w] == reqTag);
    end
  endgenerate

  assign wayMatch      = |wayHitVec;
  assign shortcutMatch = (lineMasked == lastLine);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        nextWay[s] <= '0;
        for (int w = 0; w < WAYS; w++) tagMem[s][w] <= '0;
      end
      lastLine <= '1;
    end else begin
      if (strobe.allocate) begin
        tagMem[lineIdx][curPtr] <= reqTag;
        nextWay[lineIdx] <= (curPtr == PTR_W'(WAYS - 1)) ? '0 : curPtr + PTR_W'(1);
      end
      if (strobe.touchLast) lastLine <= lineMasked;
    end
  end

endmodule

// File: rtl/cache_track_ctrl.sv
module cache_track_ctrl
  import cache_track_pkg::*;
(
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         shortcutMatch,
  input  logic         wayMatch,
  output logic         accessHit,
  output trackStrobe_t strobe
);

  logic lookupHit;
  logic readMiss;

  always_comb begin
    lookupHit = !shortcutMatch && wayMatch;
    readMiss  = !shortcutMatch && !wayMatch && !reqWrite;

    accessHit        = reqValid && (shortcutMatch || wayMatch);
    strobe.allocate  = reqValid && readMiss;
    strobe.touchLast = reqValid && (lookupHit || readMiss);
  end

endmodule

// File: rtl/cache_hit_tracker.sv
module cache_hit_tracker
  import cache_track_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_LOG2  = 12,
  parameter int ASSOC_LOG2 = 2,
  parameter int LINE_LOG2  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              accessHit
);

  trackStrobe_t ctrlStrobe;
  logic         shortcutMatch;
  logic         wayMatch;

  cache_track_dpath #(
    .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2),
    .ASSOC_LOG2(ASSOC_LOG2), .LINE_LOG2(LINE_LOG2)
  ) u_dpath (
    .clk(clk), .rst(rst), .reqAddr(reqAddr), .strobe(ctrlStrobe),
    .shortcutMatch(shortcutMatch), .wayMatch(wayMatch)
  );

  cache_track_ctrl u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite),
    .shortcutMatch(shortcutMatch), .wayMatch(wayMatch),
    .accessHit(accessHit), .strobe(ctrlStrobe)
  );

endmodule

// File: rtl/cache_track_checker.sv
module cache_track_checker
  import cache_track_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_LOG2  = 12,
  parameter int ASSOC_LOG2 = 2,
  parameter int LINE_LOG2  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              accessHit,
  input trackStrobe_t      ctrlStrobe
);

  localparam int TAG_SHIFT = SIZE_LOG2 - ASSOC_LOG2;
  localparam logic [ADDR_W-1:0] IDX_MASK =
    ~({ADDR_W{1'b1}} << TAG_SHIFT) & ({ADDR_W{1'b1}} << LINE_LOG2);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !accessHit);

  p_touch_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrlStrobe.touchLast || ctrlStrobe.allocate) |-> reqValid);

  p_alloc_read_miss_r2: assert property (@(posedge clk) disable iff (rst)
    ctrlStrobe.allocate |-> (!reqWrite && !accessHit));

  p_refill_hits_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && !accessHit) |=>
      (!(reqValid && reqAddr == $past(reqAddr)) || accessHit));

  p_write_miss_sticks_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && !accessHit) |=>
      (!(reqValid && reqAddr == $past(reqAddr)) || !accessHit));

  p_last_line_r5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && accessHit) |=>
      (!(reqValid && ((reqAddr & IDX_MASK) == ($past(reqAddr) & IDX_MASK))) || accessHit));

endmodule

bind cache_hit_tracker cache_track_checker #(
  .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2),
  .ASSOC_LOG2(ASSOC_LOG2), .LINE_LOG2(LINE_LOG2)
) u_chk (.*);

// File: tb/cache_hit_tracker_bench.sv
`timescale 1ns/1ps
module cache_hit_tracker_bench;

  localparam int ADDR_W = 32, SIZE_LOG2 = 12, ASSOC_LOG2 = 2, LINE_LOG2 = 5;
  localparam int TSH  = SIZE_LOG2 - ASSOC_LOG2;
  localparam int SETS = 1 << (TSH - LINE_LOG2);
  localparam int WAYS = 1 << ASSOC_LOG2;
  localparam logic [31:0] IMASK = ~(32'hFFFF_FFFF << TSH) & (32'hFFFF_FFFF << LINE_LOG2);

  logic clk = 0, rst = 1, reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = '0;
  logic accessHit;

  always #2.5 clk = ~clk;

  cache_hit_tracker #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2),
    .ASSOC_LOG2(ASSOC_LOG2), .LINE_LOG2(LINE_LOG2)) u_cache_hit_tracker (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .accessHit(accessHit));

  typedef struct { bit expHit; string tag; logic [31:0] addr; } item_t;
  item_t sbQ[$];
  int checkCount = 0, failCount = 0;
  bit monitorOn = 0, finished = 0;

  // reference model state
  int unsigned mTag [SETS][WAYS];
  int unsigned mPtr [SETS];
  logic [31:0] mLast;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      mPtr[s] = 0;
      for (int w = 0; w < WAYS; w++) mTag[s][w] = 0;
    end
    mLast = 32'hFFFF_FFFF;
  endtask

  function automatic bit model_access(logic [31:0] a, bit wr);
    logic [31:0] m = a & IMASK;
    int unsigned s = int'(m >> LINE_LOG2);
    int unsigned t = int'(a >> TSH);
    if (m == mLast) return 1'b1;
    for (int w = 0; w < WAYS; w++)
      if (mTag[s][w] == t) begin mLast = m; return 1'b1; end
    if (!wr) begin
      mTag[s][mPtr[s]] = t;
      mPtr[s] = (mPtr[s] + 1) % WAYS;
      mLast = m;
    end
    return 1'b0;
  endfunction

  // driver: want < 0 takes the model's answer, else the hand-derived one
  task automatic access(logic [31:0] a, bit wr, string tag, int want);
    item_t it;
    bit e;
    @(posedge clk); #1;
    e = model_access(a, wr);
    if (want >= 0) e = want[0];
    it.expHit = e; it.tag = tag; it.addr = a;
    sbQ.push_back(it);
    reqValid = 1; reqWrite = wr; reqAddr = a;
  endtask

  task automatic idle(int n, logic [31:0] a, bit wr);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reqValid = 0; reqWrite = wr; reqAddr = a + 32'(i * 4);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (monitorOn) begin
      if (reqValid) begin
        item_t it;
        checkCount++;
        if (sbQ.size() == 0) begin
          failCount++;
          $display("FAIL scoreboard empty actual=%0b expected=none", accessHit);
        end else begin
          it = sbQ.pop_front();
          if (accessHit !== it.expHit) begin
            failCount++;
            $display("FAIL %s addr=%h actual=%0b expected=%0b", it.tag, it.addr, accessHit, it.expHit);
          end
        end
      end else begin
        checkCount++;
        if (accessHit !== 1'b0) begin
          failCount++;
          $display("FAIL R6 idle cycle actual=%0b expected=0", accessHit);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  localparam logic [31:0] FILL = 32'h0000_0300; // tag 0, set 24: hits after reset

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst = 0;
    monitorOn = 1;
    idle(2, 32'h5555_0000, 1'b0);

    // R7: reset tags are 0
    access(32'h0000_0000, 0, "R7", 1);
    access(32'h0000_0123, 0, "R7", 1);
    // R2: read miss allocates, then hits; R1: offset ignored
    access(32'h1000_0040, 0, "R2", 0);
    access(FILL, 0, "R1", 1);
    access(32'h1000_005C, 0, "R1", 1);
    // R5: shortcut hit on different tag, no allocation
    access(32'h3000_0044, 0, "R5", 1);
    access(FILL, 0, "R5", 1);
    access(32'h3000_0040, 0, "R5", 0);
    // R4: write miss changes nothing
    access(32'h4000_0060, 1, "R4", 0);
    access(FILL, 0, "R4", 1);
    access(32'h4000_0060, 1, "R4", 0);
    access(32'h4000_0060, 0, "R4", 0);
    access(32'h4000_0060, 0, "R2", 1);
    access(32'h1000_0040, 1, "R4", 1);
    // R3: round robin in set 5
    access(32'h5000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h6000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h7000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h8000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h9000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h5000_00A0, 0, "R3", 0); access(FILL, 0, "R3", 1);
    access(32'h7000_00A0, 0, "R3", 1); access(FILL, 0, "R3", 1);
    access(32'h6000_00A0, 0, "R3", 0);
    // R6: idle cycles leave state alone
    idle(6, 32'h7000_00E0, 1'b0);
    access(32'hA000_00A8, 0, "R6", 1);
    access(32'h7000_00E0, 0, "R6", 0);
    idle(3, 32'hB000_0100, 1'b1);
    access(32'h7000_00E0, 0, "R6", 1);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = {$urandom_range(7, 0), 18'h0, 3'($urandom_range(3, 0)), 2'b00, 5'($urandom)} ;
      a[31:28] = 4'($urandom_range(7, 0));
      access(a, ($urandom_range(3, 0) == 0), "R1", -1);
      if ($urandom_range(7, 0) == 0) idle(1, $urandom, 1'b0);
    end

    @(posedge clk); #1 reqValid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sbQ.size() != 0) begin
      failCount++;
      $display("FAIL R1 leftover items actual=%0d expected=0", sbQ.size());
    end
    finish_run();
  end

endmodule